// File: doc/BRIEF.md
# Raster Video Timing Generator

This block runs in the pixel clock domain and produces the raster timing for a display: horizontal and vertical sync, a display-enable strobe and the current pixel and line positions. Software configures it through a small write-only register bus. It writes one packed horizontal timing word, one packed vertical timing word and a control word, and it acknowledges a retrace status flag by writing a one to that flag.

Each axis is walked by its own four-state machine. The states are `SEG_ACT` (visible area), `SEG_FP` (front porch), `SEG_SYNC` (sync pulse) and `SEG_BP` (back porch). The transitions are ACT→FP, FP→SYNC, SYNC→BP and BP→ACT, and each one fires when the segment's length has been counted out. Disabling the scan forces either machine back to `SEG_ACT`. The horizontal machine steps once per pixel clock. The vertical machine steps once per completed line. Horizontal lengths are coded in units of four pixels. Each sync has its own polarity and its own force-inactive control, so the display can be put into standby, suspend and power-off states.

Top module: `raster_timing_gen`

## Requirements
- R1: A write with `bus_we` high takes effect at the next clock edge. Address 0 is the horizontal word, 1 the vertical word and 2 the control word, where bit 0 enables scanning and bit 1 blanks. Address 3 is the status register: writing 1 in bit 0 clears the retrace flag, and writing 0 there leaves it unchanged.
- R2: In the horizontal word, the active width in four-pixel units is {bit 31, bits 8:0}, the front porch is bits 13:9, the sync width is bits 20:14 and the back porch is bits 27:21. Each field is multiplied by four to give pixels, and a field of zero counts as one unit.
- R3: In the vertical word, active lines are bits 10:0, the front porch is bits 15:11, the sync width is bits 21:16 and the back porch is bits 28:22, all in lines. A zero field counts as one line.
- R4: `pix_x` counts from 0 through the line total minus 1 and then wraps. The order along a line is active, front porch, sync, back porch. `line_y` advances when `pix_x` wraps, follows the same order in lines, and wraps to 0 at the end of the frame.
- R5: Bit 29 of each timing word sets that sync's polarity. When it is 1, the sync is high during its sync segment and low otherwise. When it is 0, the levels are inverted.
- R6: Bit 30 of a timing word holds that axis's sync at its inactive level. Bits 29 and 30 act from the cycle after the write.
- R7: With enable at 0, both positions are held at 0, both syncs are inactive and `disp_en` is low. With enable at 1 and blank at 1, scanning and syncs run but `disp_en` stays low. With enable at 1 and blank at 0, `disp_en` is high exactly when both positions lie in their active segments.
- R8: A new geometry field value is used only from the next frame start, or immediately if scanning is disabled. A frame never mixes old and new lengths.
- R9: `retrace_irq` goes high on the clock edge where the vertical machine enters `SEG_SYNC` and stays high until it is cleared. If a set and a clear fall on the same edge, the set wins.
- R10: After reset, all registers are zero. Both syncs are therefore high, `disp_en` is low, both positions are 0 and `retrace_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | High while a visible pixel is scanned |
| pix_x | output | HPOS_W | Pixel position within the line |
| line_y | output | VPOS_W | Line position within the frame |
| retrace_irq | output | 1 | Vertical retrace status flag |

## Verification
Two functions can land on the same clock edge: the vertical machine setting the retrace flag as it enters `SEG_SYNC`, and a software write-one clear of that flag. The bench predicts the cycle in which the last front-porch line ends and times the status write so that it is sampled on exactly that edge. The flag must still read 1 afterwards. A second collision is a geometry write arriving in the middle of a frame. The line in progress must finish at the old length, and the new length must appear only after the frame wraps.

// File: rtl/raster_pkg.sv
`timescale 1ns/1ps
package raster_pkg;
    typedef enum logic [1:0] {
        SEG_ACT  = 2'd0,
        SEG_FP   = 2'd1,
        SEG_SYNC = 2'd2,
        SEG_BP   = 2'd3
    } seg_e;

    localparam int WORD_W    = 32;
    localparam int POL_BIT   = 29;
    localparam int OFF_BIT   = 30;
    localparam int EN_BIT    = 0;
    localparam int BLANK_BIT = 1;

    localparam logic [1:0] ADDR_HWORD = 2'd0;
    localparam logic [1:0] ADDR_VWORD = 2'd1;
    localparam logic [1:0] ADDR_CTRL  = 2'd2;
    localparam logic [1:0] ADDR_STAT  = 2'd3;
endpackage

// File: rtl/raster_axis.sv
`timescale 1ns/1ps
module raster_axis
    import raster_pkg::*;
#(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic [CW-1:0] len_act,
    input  logic [CW-1:0] len_fp,
    input  logic [CW-1:0] len_sync,
    input  logic [CW-1:0] len_bp,
    output seg_e          seg,
    output logic [CW-1:0] pos,
    output logic          wrap,
    output logic          sync_start
);
    seg_e          seg_q, seg_d;
    logic [CW-1:0] cnt_q, cnt_d, pos_q, pos_d, cur_len;
    logic          seg_done;

    always_comb begin
        unique case (seg_q)
            SEG_ACT:  cur_len = len_act;
            SEG_FP:   cur_len = len_fp;
            SEG_SYNC: cur_len = len_sync;
            SEG_BP:   cur_len = len_bp;
        endcase
        seg_done   = run && step && (cnt_q == cur_len - 1'b1);
        wrap       = seg_done && (seg_q == SEG_BP);
        sync_start = seg_done && (seg_q == SEG_FP);

        seg_d = seg_q;
        cnt_d = cnt_q;
        pos_d = pos_q;
        if (!run) begin
            seg_d = SEG_ACT;
            cnt_d = '0;
            pos_d = '0;
        end else if (step) begin
            if (seg_done) begin
                cnt_d = '0;
                unique case (seg_q)
                    SEG_ACT:  seg_d = SEG_FP;
                    SEG_FP:   seg_d = SEG_SYNC;
                    SEG_SYNC: seg_d = SEG_BP;
                    SEG_BP:   seg_d = SEG_ACT;
                endcase
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
            pos_d = wrap ? '0 : pos_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q <= SEG_ACT;
            cnt_q <= '0;
            pos_q <= '0;
        end else begin
            seg_q <= seg_d;
            cnt_q <= cnt_d;
            pos_q <= pos_d;
        end
    end

    assign seg = seg_q;
    assign pos = pos_q;

    // R4: a wrap always returns the position to zero
    p_wrap_home_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (pos == '0));

    // R7: an idle axis sits at the start of the visible segment
    p_idle_home_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pos == '0 && seg == SEG_ACT));
endmodule

// File: rtl/raster_regs.sv
`timescale 1ns/1ps
module raster_regs
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              load_geom,
    input  logic              set_irq,
    output logic [WORD_W-1:0] h_live,
    output logic [WORD_W-1:0] v_live,
    output logic [WORD_W-1:0] h_geom,
    output logic [WORD_W-1:0] v_geom,
    output logic              scan_en,
    output logic              blank,
    output logic              irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_live  <= '0;
            v_live  <= '0;
            h_geom  <= '0;
            v_geom  <= '0;
            scan_en <= 1'b0;
            blank   <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (load_geom) begin
                h_geom <= h_live;
                v_geom <= v_live;
            end
            if (we) begin
                unique case (addr)
                    ADDR_HWORD: h_live <= wdata;
                    ADDR_VWORD: v_live <= wdata;
                    ADDR_CTRL: begin
                        scan_en <= wdata[EN_BIT];
                        blank   <= wdata[BLANK_BIT];
                    end
                    ADDR_STAT: ;
                endcase
            end
            if (set_irq)
                irq <= 1'b1;
            else if (we && addr == ADDR_STAT && wdata[0])
                irq <= 1'b0;
        end
    end

    // R9: the retrace event always leaves the flag set, even against a clear
    p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_irq |=> irq);

    // R8: geometry stays frozen inside a running frame
    p_geom_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !load_geom) |=> ($stable(h_geom) && $stable(v_geom)));
endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int HPOS_W = 13,
    parameter int VPOS_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              hsync,
    output logic              vsync,
    output logic              disp_en,
    output logic [HPOS_W-1:0] pix_x,
    output logic [VPOS_W-1:0] line_y,
    output logic              retrace_irq
);
    localparam int HACT_U = 10;
    localparam int VACT_U = 11;

    logic [WORD_W-1:0] h_live, v_live, h_geom, v_geom;
    logic              scan_en, blank;
    logic              h_wrap, v_wrap, h_sync_start, v_sync_start;
    logic              frame_end, load_geom;
    seg_e              h_seg, v_seg;
    logic [HACT_U-1:0] h_act_u;
    logic [VACT_U-1:0] v_act_u;
    logic [HPOS_W-1:0] h_len_act, h_len_fp, h_len_sync, h_len_bp;
    logic [VPOS_W-1:0] v_len_act, v_len_fp, v_len_sync, v_len_bp;

    assign frame_end = h_wrap && v_wrap;
    assign load_geom = !scan_en || frame_end;

    raster_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .load_geom (load_geom),
        .set_irq   (v_sync_start),
        .h_live    (h_live),
        .v_live    (v_live),
        .h_geom    (h_geom),
        .v_geom    (v_geom),
        .scan_en   (scan_en),
        .blank     (blank),
        .irq       (retrace_irq)
    );

    // field decode: a zero field is taken as one unit
    always_comb begin
        h_act_u    = {h_geom[31], h_geom[8:0]};
        v_act_u    = v_geom[10:0];
        h_len_act  = HPOS_W'({(h_act_u == '0) ? HACT_U'(1) : h_act_u, 2'b00});
        h_len_fp   = HPOS_W'({(h_geom[13:9]  == '0) ? 5'd1 : h_geom[13:9],  2'b00});
        h_len_sync = HPOS_W'({(h_geom[20:14] == '0) ? 7'd1 : h_geom[20:14], 2'b00});
        h_len_bp   = HPOS_W'({(h_geom[27:21] == '0) ? 7'd1 : h_geom[27:21], 2'b00});
        v_len_act  = VPOS_W'((v_act_u == '0) ? VACT_U'(1) : v_act_u);
        v_len_fp   = VPOS_W'((v_geom[15:11] == '0) ? 5'd1 : v_geom[15:11]);
        v_len_sync = VPOS_W'((v_geom[21:16] == '0) ? 6'd1 : v_geom[21:16]);
        v_len_bp   = VPOS_W'((v_geom[28:22] == '0) ? 7'd1 : v_geom[28:22]);
    end

    raster_axis #(.CW(HPOS_W)) u_hax (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (scan_en),
        .step       (1'b1),
        .len_act    (h_len_act),
        .len_fp     (h_len_fp),
        .len_sync   (h_len_sync),
        .len_bp     (h_len_bp),
        .seg        (h_seg),
        .pos        (pix_x),
        .wrap       (h_wrap),
        .sync_start (h_sync_start)
    );

    raster_axis #(.CW(VPOS_W)) u_vax (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (scan_en),
        .step       (h_wrap),
        .len_act    (v_len_act),
        .len_fp     (v_len_fp),
        .len_sync   (v_len_sync),
        .len_bp     (v_len_bp),
        .seg        (v_seg),
        .pos        (line_y),
        .wrap       (v_wrap),
        .sync_start (v_sync_start)
    );

    always_comb begin
        hsync = (scan_en && !h_live[OFF_BIT] && h_seg == SEG_SYNC) ?
                h_live[POL_BIT] : !h_live[POL_BIT];
        vsync = (scan_en && !v_live[OFF_BIT] && v_seg == SEG_SYNC) ?
                v_live[POL_BIT] : !v_live[POL_BIT];
        disp_en = scan_en && !blank && h_seg == SEG_ACT && v_seg == SEG_ACT;
    end

    logic unused_bits;
    assign unused_bits = ^{h_sync_start, h_geom[30:28], v_geom[31:29],
                           h_live[31], h_live[28:0], v_live[31], v_live[28:0]};

    // R9: the flag can only rise as the frame enters vertical sync
    p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retrace_irq) |-> (v_seg == SEG_SYNC));
endmodule

// File: tb/sim_raster_timing_gen.sv
`timescale 1ns/1ps
module sim_raster_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic        hsync, vsync, disp_en, retrace_irq;
    logic [12:0] pix_x;
    logic [11:0] line_y;

    always #2.5 clk = ~clk;

    raster_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
        .pix_x(pix_x), .line_y(line_y), .retrace_irq(retrace_irq)
    );

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;

    typedef struct packed {
        logic hs, vs, de, irq;
        logic [15:0] x, y;
    } exp_t;
    exp_t exp_q[$];

    // ---------------- reference model (from the requirements) ----------
    logic [31:0] mh, mv, mhg, mvg;
    logic [1:0]  mctl;
    logic        mirq;
    int          mx, my;
    bit          pred_set;

    function automatic int nz(input int f);
        return (f == 0) ? 1 : f;
    endfunction
    function automatic logic [31:0] mkh(int a, int fp, int s, int bp, bit pol, bit off);
        logic [31:0] w = '0;
        w[8:0] = a[8:0]; w[31] = a[9]; w[13:9] = fp[4:0];
        w[20:14] = s[6:0]; w[27:21] = bp[6:0]; w[29] = pol; w[30] = off;
        return w;
    endfunction
    function automatic logic [31:0] mkv(int a, int fp, int s, int bp, bit pol, bit off);
        logic [31:0] w = '0;
        w[10:0] = a[10:0]; w[15:11] = fp[4:0]; w[21:16] = s[5:0];
        w[28:22] = bp[6:0]; w[29] = pol; w[30] = off;
        return w;
    endfunction

    int hA, hF, hS, hB, vA, vF, vS, vB;
    task automatic geom();
        hA = 4 * nz(int'({mhg[31], mhg[8:0]}));
        hF = 4 * nz(int'(mhg[13:9]));
        hS = 4 * nz(int'(mhg[20:14]));
        hB = 4 * nz(int'(mhg[27:21]));
        vA = nz(int'(mvg[10:0]));
        vF = nz(int'(mvg[15:11]));
        vS = nz(int'(mvg[21:16]));
        vB = nz(int'(mvg[28:22]));
    endtask

    // predictor: advances the model at each edge and queues the expectation
    always @(posedge clk) begin
        if (!rst_n) begin
            mh = '0; mv = '0; mhg = '0; mvg = '0; mctl = '0; mirq = 0;
            mx = 0; my = 0; pred_set = 0;
            exp_q.delete();
        end else begin
            logic we_s; logic [1:0] ad_s; logic [31:0] wd_s;
            int nx, ny; bit load, setf;
            exp_t e;
            we_s = bus_we; ad_s = bus_addr; wd_s = bus_wdata;
            geom();
            setf = 0; load = 0;
            if (mctl[0]) begin
                if (mx == hA + hF + hS + hB - 1) begin
                    nx = 0;
                    if (my == vA + vF + vS + vB - 1) begin ny = 0; load = 1; end
                    else ny = my + 1;
                    setf = (my + 1 == vA + vF);
                end else begin
                    nx = mx + 1; ny = my;
                end
            end else begin
                nx = 0; ny = 0; load = 1;
            end
            if (load) begin mhg = mh; mvg = mv; end
            if (setf) mirq = 1;
            else if (we_s && ad_s == 2'd3 && wd_s[0]) mirq = 0;
            if (we_s) begin
                case (ad_s)
                    2'd0: mh = wd_s;
                    2'd1: mv = wd_s;
                    2'd2: mctl = wd_s[1:0];
                    default: ;
                endcase
            end
            mx = nx; my = ny;
            geom();
            e.x = 16'(mx); e.y = 16'(my); e.irq = mirq;
            e.hs = (mctl[0] && !mh[30] && mx >= hA + hF && mx < hA + hF + hS) ? mh[29] : !mh[29];
            e.vs = (mctl[0] && !mv[30] && my >= vA + vF && my < vA + vF + vS) ? mv[29] : !mv[29];
            e.de = mctl[0] && !mctl[1] && mx < hA && my < vA;
            exp_q.push_back(e);
            pred_set = mctl[0] && (mx == hA + hF + hS + hB - 1) && (my + 1 == vA + vF);
        end
    end

    task automatic chk(string tag, int act, int expv);
        n_vec++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // monitor: pops one expectation per edge, samples after the edge settles
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R2 R4 pix_x",   int'(pix_x),       int'(e.x));
                chk("R3 R4 line_y",  int'(line_y),      int'(e.y));
                chk("R5 R6 hsync",   int'(hsync),       int'(e.hs));
                chk("R5 R6 vsync",   int'(vsync),       int'(e.vs));
                chk("R7 disp_en",    int'(disp_en),     int'(e.de));
                chk("R9 retrace",    int'(retrace_irq), int'(e.irq));
            end
        end
    end

    // R1: bus driver
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int prev;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 hsync", int'(hsync), 1);
        chk("R10 vsync", int'(vsync), 1);
        chk("R10 disp_en", int'(disp_en), 0);
        chk("R10 pix_x", int'(pix_x), 0);
        chk("R10 line_y", int'(line_y), 0);
        chk("R10 retrace", int'(retrace_irq), 0);

        wr(2'd0, mkh(2, 1, 1, 1, 1, 0));   // line total 20 pixels
        wr(2'd1, mkv(3, 1, 1, 1, 0, 0));   // frame total 6 lines
        wr(2'd2, 32'h1);
        // R5: active-high hsync starts after 8 active + 4 porch pixels
        while (!hsync) @(negedge clk);
        chk("R5 hsync start", int'(pix_x), 12);
        // R2: line wraps after pixel 19
        prev = int'(pix_x);
        @(negedge clk);
        while (pix_x != 0) begin prev = int'(pix_x); @(negedge clk); end
        chk("R2 line end", prev, 19);
        repeat (260) @(negedge clk);
        // R1: writing 0 to the status bit leaves the flag set
        wr(2'd3, 32'h0);
        chk("R1 no clear", int'(retrace_irq), 1);
        wr(2'd3, 32'h1);
        chk("R9 cleared", int'(retrace_irq), int'(mirq));

        // R7 blank while scanning
        wr(2'd2, 32'h3);
        for (int i = 0; i < 130; i++) begin
            @(negedge clk);
            if (disp_en) chk("R7 blank", int'(disp_en), 0);
        end
        wr(2'd2, 32'h1);

        // R6 force each sync off
        wr(2'd0, mkh(2, 1, 1, 1, 1, 1));
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (hsync) chk("R6 hsync off", int'(hsync), 0);
        end
        wr(2'd0, mkh(2, 1, 1, 1, 1, 0));
        wr(2'd1, mkv(3, 1, 1, 1, 0, 1));
        for (int i = 0; i < 130; i++) begin
            @(negedge clk);
            if (!vsync) chk("R6 vsync off", int'(vsync), 1);
        end
        wr(2'd1, mkv(3, 1, 1, 1, 0, 0));

        // R9 set and clear on the same edge
        @(negedge clk);
        while (!pred_set) @(negedge clk);
        bus_we = 1'b1; bus_addr = 2'd3; bus_wdata = 32'h1;
        @(negedge clk);
        bus_we = 1'b0;
        chk("R9 set beats clear", int'(retrace_irq), 1);

        // R8 mid-frame geometry change
        while (line_y != 1) @(negedge clk);
        wr(2'd0, mkh(3, 2, 1, 1, 1, 0));   // new total 28 pixels
        wr(2'd1, mkv(2, 2, 1, 1, 1, 0));
        prev = int'(pix_x);
        @(negedge clk);
        while (pix_x != 0) begin prev = int'(pix_x); @(negedge clk); end
        chk("R8 old line length kept", prev, 19);
        repeat (400) @(negedge clk);

        // R7 disable holds everything at home
        wr(2'd2, 32'h0);
        repeat (3) @(negedge clk);
        chk("R7 idle x", int'(pix_x), 0);
        chk("R7 idle y", int'(line_y), 0);
        chk("R7 idle de", int'(disp_en), 0);

        // R2 R3 zero fields count as one unit
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h1);
        repeat (200) @(negedge clk);

        done = 1;
        summary();
        $finish;
    end
endmodule